// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register storage of a 32-bit processor core. It turns a 4-bit register number and the current operating mode into a slot in one flat set of 37 physical 32-bit registers. There are 31 general-purpose slots, with the program counter among them. There are also 6 status slots: one current status word shared by all modes, and one saved status word for each of the five exception modes. Instruction decode, the ALU and exception sequencing are outside this block and drive its ports.

Six operating modes are supported. In the four ordinary exception modes (normal interrupt, supervisor, abort, undefined), each mode has its own stack pointer and link register. The fast interrupt mode also gets private copies of registers 8 to 12, so its handler never has to spill them. The mode is held in a register inside the block and changes on the edge after a mode load. Two combinational read ports and one synchronous write port use the current mode. The program counter, the current status word and the saved status word of the current mode each have their own write port. A debug port reads any physical slot by its flat index, whatever the mode.

Top module: `banked_regfile`

## Requirements
- R1: While reset is high, on every rising edge all 37 physical registers clear to zero and the mode register loads supervisor (code 3).
- R2: Mode codes 0, 6 and 7 are all user mode. Register numbers 0 to 15 reach flat slots 0 to 15.
- R3: In modes 2 (normal interrupt), 3 (supervisor), 4 (abort) and 5 (undefined), registers 13 and 14 reach private slots 23+2*(mode-2) and 24+2*(mode-2). Registers 0 to 12 reach user slots 0 to 12.
- R4: In mode 1 (fast interrupt), registers 8 to 14 reach private slots 16 to 22. Registers 0 to 7 reach user slots 0 to 7.
- R5: Register 15 (program counter, slot 15) is the same in every mode. It changes only through the program-counter write port. A general write addressed to register 15 is ignored.
- R6: The current status word (slot 31) is shared by all modes. Its write port updates it on the next edge.
- R7: Modes 1 to 5 each own a saved status word in slots 32 to 36, in that order. In user mode the saved-status output reads zero and a saved-status write changes nothing.
- R8: A read of a register written in the same cycle returns the old value. The new value is readable from the next cycle.
- R9: The debug port returns flat slot 0 to 36 whatever the mode. Indices 37 to 63 return zero.
- R10: A mode load takes effect on the next edge. Any write in that same cycle is mapped with the old mode.
- R11: The two read ports return different registers at the same time, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_i | input | 1 | Load a new operating mode |
| mode_new_i | input | 3 | Mode code to load |
| mode_o | output | 3 | Current operating mode |
| rd_a_idx_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General register write enable |
| wr_idx_i | input | 4 | General write register number |
| wr_data_i | input | 32 | General write data |
| pc_we_i | input | 1 | Program counter write enable |
| pc_wdata_i | input | 32 | Program counter write data |
| cpsr_we_i | input | 1 | Current status write enable |
| cpsr_wdata_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_we_i | input | 1 | Saved status write enable for the current mode |
| spsr_wdata_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status word of the current mode, zero in user mode |
| dbg_idx_i | input | 6 | Debug flat slot index |
| dbg_data_o | output | 32 | Debug read data |

## Verification
The bench writes a distinct value through every mode and then inspects each physical slot. A mapping that shares one bank across modes, or misplaces the fast interrupt range, shows up as a wrong slot value. Codes 6 and 7 are exercised so that a decoder treating them as exception modes reads stale or foreign copies. Writing register 15 through the general port catches a design that lets it bypass the dedicated program-counter enable. The cycle that loads a new mode also carries a write, which exposes a design that maps that write with the new mode. A same-cycle read and write exposes a design that forwards the new value. A saved-status write in user mode exposes a design that lets it land in some exception mode's slot.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

    localparam int XLEN       = 32;
    localparam int ARCH_REGS  = 16;
    localparam int AIDX_W     = $clog2(ARCH_REGS);
    localparam int MODE_W     = 3;

    localparam int FIQ_FIRST  = 8;
    localparam int FIQ_LAST   = 14;
    localparam int FIQ_COUNT  = FIQ_LAST - FIQ_FIRST + 1;
    localparam int SP_ARCH    = 13;
    localparam int LR_ARCH    = 14;
    localparam int PC_ARCH    = 15;
    localparam int PAIR_MODES = 4;

    localparam int PC_SLOT    = PC_ARCH;
    localparam int FIQ_BASE   = ARCH_REGS;
    localparam int PAIR_BASE  = FIQ_BASE + FIQ_COUNT;
    localparam int GPR_PHYS   = PAIR_BASE + 2 * PAIR_MODES;
    localparam int CPSR_SLOT  = GPR_PHYS;
    localparam int SPSR_BASE  = CPSR_SLOT + 1;
    localparam int SPSR_COUNT = 5;
    localparam int PHYS_REGS  = SPSR_BASE + SPSR_COUNT;
    localparam int PIDX_W     = $clog2(PHYS_REGS);

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 3'd0,
        MODE_FIQ = 3'd1,
        MODE_IRQ = 3'd2,
        MODE_SVC = 3'd3,
        MODE_ABT = 3'd4,
        MODE_UND = 3'd5
    } cpu_mode_e;

    typedef struct packed {
        logic              hit;
        logic [PIDX_W-1:0] slot;
    } slot_sel_t;

    function automatic logic is_pair_mode(input logic [MODE_W-1:0] mode);
        return (mode >= MODE_IRQ) && (mode <= MODE_UND);
    endfunction

    function automatic logic [PIDX_W-1:0] gpr_slot(input logic [MODE_W-1:0] mode,
                                                    input logic [AIDX_W-1:0] idx);
        int s;
        s = int'(idx);
        if (mode == MODE_FIQ && int'(idx) >= FIQ_FIRST && int'(idx) <= FIQ_LAST)
            s = FIQ_BASE + int'(idx) - FIQ_FIRST;
        else if (is_pair_mode(mode) && int'(idx) >= SP_ARCH && int'(idx) <= LR_ARCH)
            s = PAIR_BASE + 2 * (int'(mode) - int'(MODE_IRQ)) + int'(idx) - SP_ARCH;
        return PIDX_W'(s);
    endfunction

    function automatic slot_sel_t spsr_slot(input logic [MODE_W-1:0] mode);
        slot_sel_t r;
        r.hit  = (mode >= MODE_FIQ) && (mode <= MODE_UND);
        r.slot = r.hit ? PIDX_W'(SPSR_BASE + int'(mode) - int'(MODE_FIQ)) : '0;
        return r;
    endfunction

endpackage

// File: rtl/rf_mode_reg.sv
module rf_mode_reg
    import banked_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_in,
    output logic [MODE_W-1:0] mode_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_SVC;
        else if (load)
            mode_q <= mode_in;
    end
endmodule

// File: rtl/rf_slot_map.sv
module rf_slot_map
    import banked_rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [AIDX_W-1:0] idx,
    output logic [PIDX_W-1:0] slot
);
    always_comb slot = gpr_slot(mode, idx);
endmodule

// File: rtl/rf_phys_store.sv
module rf_phys_store
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int DEPTH  = PHYS_REGS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          gpr_we,
    input  logic [PIDX_W-1:0]             gpr_slot_i,
    input  logic [DATA_W-1:0]             gpr_data,
    input  logic                          pc_we,
    input  logic [DATA_W-1:0]             pc_data,
    input  logic                          cpsr_we,
    input  logic [DATA_W-1:0]             cpsr_data,
    input  logic                          spsr_we,
    input  logic [PIDX_W-1:0]             spsr_slot_i,
    input  logic [DATA_W-1:0]             spsr_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  regs_o
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i == PC_SLOT) begin : g_pc
            always_ff @(posedge clk) begin
                if (rst)        regs_o[i] <= '0;
                else if (pc_we) regs_o[i] <= pc_data;
            end
        end else if (i == CPSR_SLOT) begin : g_cpsr
            always_ff @(posedge clk) begin
                if (rst)          regs_o[i] <= '0;
                else if (cpsr_we) regs_o[i] <= cpsr_data;
            end
        end else if (i >= SPSR_BASE) begin : g_spsr
            always_ff @(posedge clk) begin
                if (rst)
                    regs_o[i] <= '0;
                else if (spsr_we && spsr_slot_i == PIDX_W'(i))
                    regs_o[i] <= spsr_data;
            end
        end else begin : g_gpr
            always_ff @(posedge clk) begin
                if (rst)
                    regs_o[i] <= '0;
                else if (gpr_we && gpr_slot_i == PIDX_W'(i))
                    regs_o[i] <= gpr_data;
            end
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr_i,
    input  logic [MODE_W-1:0] mode_new_i,
    output logic [MODE_W-1:0] mode_o,
    input  logic [AIDX_W-1:0] rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [AIDX_W-1:0] rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [AIDX_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pc_we_i,
    input  logic [DATA_W-1:0] pc_wdata_i,
    input  logic              cpsr_we_i,
    input  logic [DATA_W-1:0] cpsr_wdata_i,
    output logic [DATA_W-1:0] cpsr_o,
    input  logic              spsr_we_i,
    input  logic [DATA_W-1:0] spsr_wdata_i,
    output logic [DATA_W-1:0] spsr_o,
    input  logic [PIDX_W-1:0] dbg_idx_i,
    output logic [DATA_W-1:0] dbg_data_o
);
    localparam int NPORTS = 3;

    logic [MODE_W-1:0]               mode_q;
    logic [PHYS_REGS-1:0][DATA_W-1:0] phys_q;
    logic [AIDX_W-1:0]               port_idx  [NPORTS];
    logic [PIDX_W-1:0]               port_slot [NPORTS];
    slot_sel_t                       spsr_sel;
    logic                            gpr_we;

    rf_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .load    (mode_wr_i),
        .mode_in (mode_new_i),
        .mode_q  (mode_q)
    );

    assign port_idx[0] = rd_a_idx_i;
    assign port_idx[1] = rd_b_idx_i;
    assign port_idx[2] = wr_idx_i;

    for (genvar p = 0; p < NPORTS; p++) begin : g_map
        rf_slot_map u_map (
            .mode (mode_q),
            .idx  (port_idx[p]),
            .slot (port_slot[p])
        );
    end

    always_comb begin
        spsr_sel = spsr_slot(mode_q);
        gpr_we   = wr_en_i && (wr_idx_i != AIDX_W'(PC_ARCH));
    end

    rf_phys_store #(.DATA_W(DATA_W), .DEPTH(PHYS_REGS)) u_store (
        .clk         (clk),
        .rst         (rst),
        .gpr_we      (gpr_we),
        .gpr_slot_i  (port_slot[2]),
        .gpr_data    (wr_data_i),
        .pc_we       (pc_we_i),
        .pc_data     (pc_wdata_i),
        .cpsr_we     (cpsr_we_i),
        .cpsr_data   (cpsr_wdata_i),
        .spsr_we     (spsr_we_i && spsr_sel.hit),
        .spsr_slot_i (spsr_sel.slot),
        .spsr_data   (spsr_wdata_i),
        .regs_o      (phys_q)
    );

    always_comb begin
        mode_o      = mode_q;
        rd_a_data_o = phys_q[port_slot[0]];
        rd_b_data_o = phys_q[port_slot[1]];
        cpsr_o      = phys_q[CPSR_SLOT];
        spsr_o      = spsr_sel.hit ? phys_q[spsr_sel.slot] : '0;
        dbg_data_o  = (int'(dbg_idx_i) < PHYS_REGS) ? phys_q[dbg_idx_i] : '0;
    end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           mode_wr_i,
    input logic [MODE_W-1:0]              mode_new_i,
    input logic [MODE_W-1:0]              mode_o,
    input logic                           wr_en_i,
    input logic [AIDX_W-1:0]              wr_idx_i,
    input logic [DATA_W-1:0]              wr_data_i,
    input logic [AIDX_W-1:0]              rd_a_idx_i,
    input logic [DATA_W-1:0]              rd_a_data_o,
    input logic                           pc_we_i,
    input logic [DATA_W-1:0]              pc_wdata_i,
    input logic                           cpsr_we_i,
    input logic [DATA_W-1:0]              cpsr_wdata_i,
    input logic [DATA_W-1:0]              cpsr_o,
    input logic                           spsr_we_i,
    input logic [PHYS_REGS-1:0][DATA_W-1:0] phys_q
);
    logic user_mode;
    assign user_mode = (mode_o == MODE_USR) || (mode_o > MODE_UND);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == MODE_SVC && cpsr_o == '0));

    // R5
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pc_we_i |=> $stable(phys_q[PC_SLOT]));

    // R6
    cpsr_update_chk: assert property (@(posedge clk) disable iff (rst)
        cpsr_we_i |=> (cpsr_o == $past(cpsr_wdata_i)));

    // R7
    user_spsr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (spsr_we_i && user_mode) |=> $stable(phys_q[PHYS_REGS-1:SPSR_BASE]));

    // R8
    gpr_write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_idx_i != AIDX_W'(PC_ARCH)) |=>
            ((rd_a_idx_i == $past(wr_idx_i) && $stable(mode_o)) ->
                (rd_a_data_o == $past(wr_data_i))));

    // R10
    mode_load_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr_i |=> (mode_o == $past(mode_new_i)));
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .mode_wr_i    (mode_wr_i),
    .mode_new_i   (mode_new_i),
    .mode_o       (mode_o),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (wr_idx_i),
    .wr_data_i    (wr_data_i),
    .rd_a_idx_i   (rd_a_idx_i),
    .rd_a_data_o  (rd_a_data_o),
    .pc_we_i      (pc_we_i),
    .pc_wdata_i   (pc_wdata_i),
    .cpsr_we_i    (cpsr_we_i),
    .cpsr_wdata_i (cpsr_wdata_i),
    .cpsr_o       (cpsr_o),
    .spsr_we_i    (spsr_we_i),
    .phys_q       (phys_q)
);

// File: tb/banked_regfile_tb_top.sv
module banked_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr = 1'b0;
    logic [2:0]  mode_new = '0;
    logic [2:0]  mode_o;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        pc_we = 1'b0;
    logic [31:0] pc_wdata = '0;
    logic        cpsr_we = 1'b0;
    logic [31:0] cpsr_wdata = '0, cpsr_o;
    logic        spsr_we = 1'b0;
    logic [31:0] spsr_wdata = '0, spsr_o;
    logic [5:0]  dbg_idx = '0;
    logic [31:0] dbg_data;

    int n_tests = 0;
    int n_fail  = 0;

    banked_regfile dut_i (
        .clk(clk), .rst(rst),
        .mode_wr_i(mode_wr), .mode_new_i(mode_new), .mode_o(mode_o),
        .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
        .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .pc_we_i(pc_we), .pc_wdata_i(pc_wdata),
        .cpsr_we_i(cpsr_we), .cpsr_wdata_i(cpsr_wdata), .cpsr_o(cpsr_o),
        .spsr_we_i(spsr_we), .spsr_wdata_i(spsr_wdata), .spsr_o(spsr_o),
        .dbg_idx_i(dbg_idx), .dbg_data_o(dbg_data)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_dbg(input string req, input int idx, input logic [31:0] exp);
        dbg_idx = 6'(idx);
        #1;
        check(req, dbg_data, exp);
    endtask

    task automatic chk_rd_a(input string req, input int idx, input logic [31:0] exp);
        rd_a_idx = 4'(idx);
        #1;
        check(req, rd_a_data, exp);
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_wr = 1'b1; mode_new = m;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wr_gpr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_pc(input logic [31:0] d);
        @(negedge clk);
        pc_we = 1'b1; pc_wdata = d;
        @(negedge clk);
        pc_we = 1'b0;
    endtask

    task automatic wr_spsr(input logic [31:0] d);
        @(negedge clk);
        spsr_we = 1'b1; spsr_wdata = d;
        @(negedge clk);
        spsr_we = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 mode after reset", 32'(mode_o), 32'd3);
        for (int i = 0; i < 37; i++) chk_dbg("R1 slot cleared", i, 32'h0);
    endtask

    task automatic t_user_map();
        set_mode(3'd0);
        for (int i = 0; i < 15; i++) wr_gpr(i, 32'h1000 + i);
        wr_pc(32'h0000_ABC0);
        for (int i = 0; i < 16; i++)
            chk_dbg("R2 user slot", i, (i == 15) ? 32'h0000_ABC0 : 32'h1000 + i);
        chk_rd_a("R2 user read r14", 14, 32'h100E);
        rd_a_idx = 4'd2; rd_b_idx = 4'd11;
        #1;
        check("R11 port A", rd_a_data, 32'h1002);
        check("R11 port B", rd_b_data, 32'h100B);
    endtask

    task automatic t_fiq_map();
        set_mode(3'd1);
        for (int i = 8; i < 15; i++) wr_gpr(i, 32'hF000 + i);
        for (int i = 8; i < 15; i++) chk_dbg("R4 fiq private slot", 16 + i - 8, 32'hF000 + i);
        for (int i = 8; i < 15; i++) chk_dbg("R4 user copy untouched", i, 32'h1000 + i);
        chk_rd_a("R4 fiq reads user r7", 7, 32'h1007);
        chk_rd_a("R4 fiq reads private r12", 12, 32'hF00C);
        chk_rd_a("R5 pc in fiq", 15, 32'h0000_ABC0);
    endtask

    task automatic t_pair_banks();
        for (int m = 2; m <= 5; m++) begin
            set_mode(3'(m));
            wr_gpr(13, (32'(m) << 12) | 32'hD);
            wr_gpr(14, (32'(m) << 12) | 32'hE);
            chk_dbg("R3 private sp slot", 23 + 2 * (m - 2), (32'(m) << 12) | 32'hD);
            chk_dbg("R3 private lr slot", 24 + 2 * (m - 2), (32'(m) << 12) | 32'hE);
            chk_rd_a("R3 shared r12", 12, 32'h100C);
            chk_rd_a("R3 shared r8", 8, 32'h1008);
        end
        set_mode(3'd0);
        chk_rd_a("R3 user sp intact", 13, 32'h100D);
        chk_dbg("R3 fiq sp intact", 21, 32'hF00D);
    endtask

    task automatic t_alias_codes();
        set_mode(3'd6);
        chk_rd_a("R2 code 6 reads user sp", 13, 32'h100D);
        wr_gpr(10, 32'h6666);
        chk_dbg("R2 code 6 writes user slot", 10, 32'h6666);
        set_mode(3'd7);
        chk_rd_a("R2 code 7 reads user r10", 10, 32'h6666);
        chk_dbg("R2 fiq r10 untouched", 18, 32'hF00A);
    endtask

    task automatic t_pc();
        set_mode(3'd3);
        wr_gpr(15, 32'hDEAD_BEEF);
        chk_rd_a("R5 general write to r15 ignored", 15, 32'h0000_ABC0);
        wr_pc(32'h0000_2000);
        set_mode(3'd1);
        chk_rd_a("R5 pc shared in fiq", 15, 32'h0000_2000);
        chk_dbg("R5 pc slot", 15, 32'h0000_2000);
    endtask

    task automatic t_cpsr();
        set_mode(3'd2);
        @(negedge clk);
        cpsr_we = 1'b1; cpsr_wdata = 32'h0000_001F;
        @(negedge clk);
        cpsr_we = 1'b0;
        set_mode(3'd0);
        #1;
        check("R6 cpsr shared", cpsr_o, 32'h0000_001F);
        chk_dbg("R6 cpsr slot", 31, 32'h0000_001F);
    endtask

    task automatic t_spsr();
        for (int m = 1; m <= 5; m++) begin
            set_mode(3'(m));
            wr_spsr(32'h5000 + m);
            #1;
            check("R7 spsr readback", spsr_o, 32'h5000 + m);
        end
        for (int m = 1; m <= 5; m++) chk_dbg("R7 spsr slot", 31 + m, 32'h5000 + m);
        set_mode(3'd0);
        #1;
        check("R7 user spsr reads zero", spsr_o, 32'h0);
        wr_spsr(32'h0000_0BAD);
        #1;
        check("R7 user spsr still zero", spsr_o, 32'h0);
        for (int m = 1; m <= 5; m++) chk_dbg("R7 user spsr write ignored", 31 + m, 32'h5000 + m);
        set_mode(3'd6);
        wr_spsr(32'h0000_0BAD);
        chk_dbg("R7 code 6 spsr write ignored", 36, 32'h5005);
    endtask

    task automatic t_read_during_write();
        set_mode(3'd3);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3333;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        #1;
        check("R8 port A old value", rd_a_data, 32'h1003);
        check("R8 port B old value", rd_b_data, 32'h1003);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8 port A new value", rd_a_data, 32'h3333);
        check("R8 port B new value", rd_b_data, 32'h3333);
    endtask

    task automatic t_mode_same_cycle();
        set_mode(3'd0);
        @(negedge clk);
        mode_wr = 1'b1; mode_new = 3'd1;
        wr_en = 1'b1; wr_idx = 4'd9; wr_data = 32'h9999;
        @(negedge clk);
        mode_wr = 1'b0; wr_en = 1'b0;
        #1;
        check("R10 mode loaded", 32'(mode_o), 32'd1);
        chk_dbg("R10 write used old mode", 9, 32'h9999);
        chk_dbg("R10 fiq r9 untouched", 17, 32'hF009);
    endtask

    task automatic t_dbg_range();
        set_mode(3'd4);
        chk_dbg("R9 flat slot regardless of mode", 21, 32'hF00D);
        chk_dbg("R9 index 37 reads zero", 37, 32'h0);
        chk_dbg("R9 index 63 reads zero", 63, 32'h0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_user_map();
        t_fiq_map();
        t_pair_banks();
        t_alias_codes();
        t_pc();
        t_cpsr();
        t_spsr();
        t_read_during_write();
        t_mode_same_cycle();
        t_dbg_range();
        t_reset();
        summary();
        $finish;
    end
endmodule